// File: doc/BRIEF.md
# Bus-Timed Scanline Clock with Interrupt Counter

This block produces a once-per-scanline clock for a cartridge interrupt counter. It never looks at the video chip. It only sees the CPU bus clock and whether each CPU cycle addresses the upper half of memory, where the cartridge ROM lives. A long stretch of CPU cycles away from that window happens about once per frame. That stretch occurs during vertical blanking, when code runs from RAM or a sprite DMA transfer is in progress. The block treats it as a frame marker and restarts its timing from it.

After each frame marker, the block waits a fixed number of scanline periods. It then emits one single-cycle pulse per scanline period until the next marker arrives. Each pulse steps an 8-bit down-counter. That counter reloads from a software-written latch and raises an interrupt when it reaches zero. Software reaches the counter through a 2-bit register select with a write strobe. A separate active-low acknowledge pin also clears the interrupt. When that pin is tied high, it has no effect.

All logic runs on the CPU bus clock and uses a synchronous, active-high reset. There is no streaming data path: every pin is a plain control or status signal.

Top module: `cpu_scanline_clock`

## Requirements
- R1: While `rst` is high, `scan_pulse` and `irq` are 0. Reset counts as a frame marker: with `cpu_a15` held at 1, the first `scan_pulse` appears LEAD_LINES·LINE_CYCLES clock edges after the last edge at which `rst` was sampled high (1482 with the default parameters).
- R2: A frame marker is detected on the RUN_MIN-th consecutive cycle with `cpu_a15` = 0 (8 by default). With `cpu_a15` returning to 1 after exactly RUN_MIN such cycles, the first pulse appears LEAD_LINES·LINE_CYCLES edges after the last edge of the run.
- R3: A run of fewer than RUN_MIN cycles with `cpu_a15` = 0, ended by any cycle with `cpu_a15` = 1, restarts nothing. The next pulse still arrives LINE_CYCLES edges after the previous one.
- R4: While a run longer than RUN_MIN continues, the timing stays held at its starting point. The first pulse is counted from the last edge of the run, not its start.
- R5: Once the initial delay has passed, `scan_pulse` is high for exactly one cycle every LINE_CYCLES cycles (114 by default) until the next frame marker.
- R6: On a pulse, the counter loads the latch value if it is 0 or a reload has been requested, and clears the request. Otherwise it decrements by one.
- R7: `irq` rises on the edge of a pulse whose updated counter value is 0 while the interrupt is enabled. It never rises without a pulse. With latch value 0, every pulse raises it.
- R8: Once set, `irq` stays high until a disable write or a cycle with `irq_ack_n` = 0. A disable write also stops later pulses from raising it.
- R9: A write with `reg_wr` = 1 selects by `reg_sel`: 0 stores `reg_wdata` in the latch, 1 requests a reload, 2 disables and clears the interrupt, 3 enables it. A reload request written in the same cycle as a pulse survives to the next pulse.
- R10: `irq_ack_n` held at 1 has no effect on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock (M2); all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_a15 | input | 1 | 1 when the current CPU cycle addresses $8000–$FFFF |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 2 | Register select: 0 latch, 1 reload, 2 disable, 3 enable |
| reg_wdata | input | 8 | Write data, used by the latch register |
| irq_ack_n | input | 1 | Active-low interrupt acknowledge; tie high when unused |
| scan_pulse | output | 1 | Single-cycle scanline clock |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default parameters: 114-cycle lines, a 13-line lead-in and an 8-cycle marker threshold. With these values the first pulse after a marker lands 1482 edges later, so the lead-in delay, the periodic train and several counter wrap-arounds all fit in one run. Runs of exactly 7, 8 and 12 off-window cycles bring the threshold edge and the hold behaviour of long runs into reach. Random stretches mix short gaps, frame markers, register writes that collide with pulses, and acknowledge pulses.

// File: rtl/scan_clk_pkg.sv
package scan_clk_pkg;
  typedef enum logic [1:0] {
    SEL_LATCH  = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_OFF    = 2'd2,
    SEL_ON     = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rom_gap_detect.sv
module rom_gap_detect #(
  parameter int RUN_MIN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic in_window,
  output logic resync
);
  localparam int RUN_W = $clog2(RUN_MIN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_MIN - 1);
  localparam logic [RUN_W-1:0] RUN_SAT  = RUN_W'(RUN_MIN);

  logic [RUN_W-1:0] run_q;

  // Marker: this off-window cycle completes a qualifying run.
  assign resync = !in_window && (run_q >= RUN_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (in_window) begin
      run_q <= '0;
    end else if (run_q != RUN_SAT) begin
      run_q <= run_q + 1'b1;
    end
  end

  a_r2_run_saturates: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_SAT);
  a_r3_window_clears_run: assert property (@(posedge clk) disable iff (rst)
    in_window |=> (run_q == '0));
endmodule

// File: rtl/line_timer.sv
module line_timer #(
  parameter int LINE_CYCLES = 114,
  parameter int LEAD_LINES  = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic resync,
  output logic tick,
  output logic pulse
);
  localparam int CYC_W  = $clog2(LINE_CYCLES);
  localparam int LEAD_W = $clog2(LEAD_LINES + 1);
  localparam logic [CYC_W-1:0]  CYC_END  = CYC_W'(LINE_CYCLES - 1);
  localparam logic [LEAD_W-1:0] LEAD_END = LEAD_W'(LEAD_LINES - 1);

  logic [CYC_W-1:0]  cyc_q;
  logic [LEAD_W-1:0] lead_q;
  logic              pulse_q;
  logic              wrap;

  assign wrap  = (cyc_q == CYC_END);
  assign tick  = !resync && wrap && (lead_q == LEAD_END);
  assign pulse = pulse_q;

  always_ff @(posedge clk) begin
    if (rst || resync) begin
      cyc_q  <= '0;
      lead_q <= '0;
    end else begin
      cyc_q <= wrap ? '0 : cyc_q + 1'b1;
      if (wrap && (lead_q != LEAD_END)) begin
        lead_q <= lead_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= tick;
    end
  end

  a_r5_single_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
  a_r4_marker_holds_phase: assert property (@(posedge clk) disable iff (rst)
    resync |=> (cyc_q == '0 && lead_q == '0 && !tick));
  a_r1_lead_bounded: assert property (@(posedge clk) disable iff (rst)
    lead_q <= LEAD_END);
endmodule

// File: rtl/irq_downcount.sv
module irq_downcount
  import scan_clk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ack_n,
  output logic             irq
);
  logic [CNT_W-1:0] latch_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;
  logic             reload_q;
  logic             en_q;
  logic             irq_q;
  logic             wr_off;
  logic             irq_set;
  logic             irq_clr;

  assign wr_off   = wr_en && (reg_sel_e'(wr_sel) == SEL_OFF);
  assign cnt_next = ((cnt_q == '0) || reload_q) ? latch_q : cnt_q - 1'b1;
  assign irq_set  = tick && en_q && (cnt_next == '0);
  assign irq_clr  = wr_off || !ack_n;
  assign irq      = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q  <= '0;
      cnt_q    <= '0;
      reload_q <= 1'b0;
      en_q     <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (tick) begin
        cnt_q <= cnt_next;
      end
      if (wr_en && reg_sel_e'(wr_sel) == SEL_RELOAD) begin
        reload_q <= 1'b1;
      end else if (tick) begin
        reload_q <= 1'b0;
      end
      if (wr_en && reg_sel_e'(wr_sel) == SEL_LATCH) begin
        latch_q <= wr_data;
      end
      if (wr_off) begin
        en_q <= 1'b0;
      end else if (wr_en && reg_sel_e'(wr_sel) == SEL_ON) begin
        en_q <= 1'b1;
      end
      if (irq_clr) begin
        irq_q <= 1'b0;
      end else if (irq_set) begin
        irq_q <= 1'b1;
      end
    end
  end

  a_r8_disable_clears: assert property (@(posedge clk) disable iff (rst)
    wr_off |=> !irq_q);
  a_r7_rise_needs_tick: assert property (@(posedge clk) disable iff (rst)
    (!irq_q && !tick) |=> !irq_q);
  a_r10_idle_ack_keeps: assert property (@(posedge clk) disable iff (rst)
    (irq_q && ack_n && !wr_off) |=> irq_q);
  a_r6_count_steps_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/cpu_scanline_clock.sv
module cpu_scanline_clock #(
  parameter int LINE_CYCLES = 114,
  parameter int LEAD_LINES  = 13,
  parameter int RUN_MIN     = 8,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_a15,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic             irq_ack_n,
  output logic             scan_pulse,
  output logic             irq
);
  logic resync;
  logic tick;

  rom_gap_detect #(.RUN_MIN(RUN_MIN)) u_gap (
    .clk       (clk),
    .rst       (rst),
    .in_window (cpu_a15),
    .resync    (resync)
  );

  line_timer #(.LINE_CYCLES(LINE_CYCLES), .LEAD_LINES(LEAD_LINES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .resync (resync),
    .tick   (tick),
    .pulse  (scan_pulse)
  );

  irq_downcount #(.CNT_W(CNT_W)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .wr_en   (reg_wr),
    .wr_sel  (reg_sel),
    .wr_data (reg_wdata),
    .ack_n   (irq_ack_n),
    .irq     (irq)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!scan_pulse && !irq));
endmodule

// File: tb/sim_cpu_scanline_clock.sv
module sim_cpu_scanline_clock;
  localparam int CLK_PERIOD = 10;
  localparam int LINE = 114;
  localparam int LEAD = 13;
  localparam int RUNM = 8;
  localparam int FIRST_GAP = LINE * LEAD;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_a15 = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic       irq_ack_n = 1'b1;
  logic       scan_pulse;
  logic       irq;

  int tests = 0;
  int fails = 0;
  int cyc_n = 0;
  int last_pulse = -1;
  bit done = 1'b0;

  cpu_scanline_clock u0 (
    .clk(clk), .rst(rst), .cpu_a15(cpu_a15), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .irq_ack_n(irq_ack_n),
    .scan_pulse(scan_pulse), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model built from the requirements.
  int   m_run, m_cyc, m_lead, m_cnt, m_latch;
  logic m_pulse, m_rl, m_en, m_irq;

  function automatic bit model_resync(logic a15, int run);
    return !a15 && run >= RUNM - 1;
  endfunction

  function automatic int model_next(int cnt, logic rl, int latch);
    return (cnt == 0 || rl) ? latch : (cnt - 1);
  endfunction

  always @(posedge clk) begin
    cyc_n <= cyc_n + 1;
    if (rst) begin
      m_run = 0; m_cyc = 0; m_lead = 0; m_pulse = 0;
      m_cnt = 0; m_latch = 0; m_rl = 0; m_en = 0; m_irq = 0;
    end else begin
      automatic bit rs = model_resync(cpu_a15, m_run);
      automatic bit tk = 0;
      automatic int nc = model_next(m_cnt, m_rl, m_latch);
      automatic bit old_en = m_en;
      m_run = cpu_a15 ? 0 : (m_run < RUNM ? m_run + 1 : m_run);
      if (rs) begin
        m_cyc = 0; m_lead = 0;
      end else begin
        tk = (m_cyc == LINE - 1) && (m_lead == LEAD - 1);
        if (m_cyc == LINE - 1) begin
          m_cyc = 0;
          if (m_lead < LEAD - 1) m_lead = m_lead + 1;
        end else m_cyc = m_cyc + 1;
      end
      m_pulse = tk;
      if (tk) begin m_cnt = nc; m_rl = 0; end
      if (reg_wr && reg_sel == 2'd0) m_latch = reg_wdata;
      if (reg_wr && reg_sel == 2'd1) m_rl = 1;
      if (reg_wr && reg_sel == 2'd2) m_en = 0;
      if (reg_wr && reg_sel == 2'd3) m_en = 1;
      if ((reg_wr && reg_sel == 2'd2) || !irq_ack_n) m_irq = 0;
      else if (tk && old_en && nc == 0) m_irq = 1;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc_n);
    end
  endtask

  // Per-cycle comparison against the model, plus pulse bookkeeping.
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(scan_pulse === m_pulse, "R5 pulse vs model", int'(scan_pulse), int'(m_pulse));
      check(irq === m_irq, "R7 irq vs model", int'(irq), int'(m_irq));
      if (scan_pulse) last_pulse = cyc_n;
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wait_pulse(output int at);
    at = -1;
    for (int i = 0; i < 3000; i++) begin
      step();
      if (scan_pulse) begin at = cyc_n; return; end
    end
  endtask

  task automatic write_reg(logic [1:0] sel, logic [7:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    step();
    reg_wr = 0;
  endtask

  task automatic off_run(int n, output int mark);
    cpu_a15 = 0;
    for (int i = 0; i < n; i++) step();
    mark = cyc_n;
    cpu_a15 = 1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int mark, at, prev;
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R1: reset state
    check(scan_pulse === 0 && irq === 0, "R1 reset outputs", int'(scan_pulse) + 2*int'(irq), 0);
    rst = 0;
    mark = cyc_n;
    wait_pulse(at);
    check(at - mark == FIRST_GAP, "R1 first pulse after reset", at - mark, FIRST_GAP);
    step();
    check(scan_pulse === 0, "R5 pulse single cycle", int'(scan_pulse), 0);
    prev = at;
    wait_pulse(at);
    check(at - prev == LINE, "R5 period", at - prev, LINE);
    // R2: exact-threshold marker
    repeat (20) step();
    off_run(RUNM, mark);
    wait_pulse(at);
    check(at - mark == FIRST_GAP, "R2 marker at threshold", at - mark, FIRST_GAP);
    // R4: long run counted from its end
    repeat (30) step();
    off_run(12, mark);
    wait_pulse(at);
    check(at - mark == FIRST_GAP, "R4 long run holds", at - mark, FIRST_GAP);
    // R3: short run ignored
    prev = at;
    repeat (40) step();
    off_run(RUNM - 1, mark);
    wait_pulse(at);
    check(at - prev == LINE, "R3 short run ignored", at - prev, LINE);
    // R6/R7/R9: latch 2, reload, enable
    repeat (5) step();
    write_reg(2'd0, 8'd2);
    write_reg(2'd1, 8'd0);
    write_reg(2'd3, 8'd0);
    wait_pulse(at);
    check(irq === 0, "R6 reload to latch", int'(irq), 0);
    wait_pulse(at);
    check(irq === 0, "R6 decrement to 1", int'(irq), 0);
    wait_pulse(at);
    check(irq === 1, "R7 irq at zero", int'(irq), 1);
    repeat (20) step();
    check(irq === 1, "R10 ack high no effect", int'(irq), 1);
    irq_ack_n = 0; step(); irq_ack_n = 1;
    check(irq === 0, "R8 ack low clears", int'(irq), 0);
    wait_pulse(at);
    check(irq === 0, "R6 reload from zero", int'(irq), 0);
    wait_pulse(at); wait_pulse(at);
    check(irq === 1, "R7 irq again", int'(irq), 1);
    write_reg(2'd2, 8'd0);
    check(irq === 0, "R8 disable write clears", int'(irq), 0);
    wait_pulse(at); wait_pulse(at); wait_pulse(at);
    check(irq === 0, "R8 disabled stays low", int'(irq), 0);
    // R7: latch 0 fires every pulse
    write_reg(2'd0, 8'd0);
    write_reg(2'd1, 8'd0);
    write_reg(2'd3, 8'd0);
    wait_pulse(at);
    check(irq === 1, "R7 latch zero fires", int'(irq), 1);
    irq_ack_n = 0; step(); irq_ack_n = 1;
    wait_pulse(at);
    check(irq === 1, "R7 latch zero fires again", int'(irq), 1);
    // Random mix, checked against the model every cycle (R2..R10)
    for (int i = 0; i < 40000; i++) begin
      automatic int r = $urandom_range(0, 999);
      if (r < 3) begin
        off_run($urandom_range(RUNM, RUNM + 6), mark);
      end else if (r < 15) begin
        off_run($urandom_range(1, RUNM - 1), mark);
      end else if (r < 25) begin
        reg_wr = 1; reg_sel = 2'($urandom_range(0, 3));
        reg_wdata = 8'($urandom_range(0, 4));
        step(); reg_wr = 0;
      end else if (r < 30) begin
        irq_ack_n = 0; step(); irq_ack_n = 1;
      end else begin
        step();
      end
    end
    finish_run();
  end
endmodule